// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Core

This core gathers eight interrupt request lines into a request register, filters them through a per-level mask and resolves the most urgent pending level. Level 0 ranks highest and level 7 lowest. It raises an interrupt output to the processor whenever an unmasked pending level outranks every level already being serviced. Nested servicing works because a lower level waits until the higher in-service levels are retired.

An external acknowledge sequencer drives two strobes. The vector-setting strobe moves the winning level from the request register into the in-service register and latches its number. The end strobe marks the end of the final acknowledge pulse. In that slot the automatic end-of-interrupt mode retires the level just granted. Without automatic mode, software issues a non-specific end-of-interrupt command, which retires the most urgent in-service level. Requests may be edge- or level-sensitive. An acknowledge that finds no pending request reports level 7.

Top module: `pic_core`

## Requirements
- R1: When several unmasked levels are pending, an acknowledge grants the lowest-numbered one (level 0 highest priority).
- R2: With `level_mode_i` low, a request bit is set only by a low-to-high transition of its input and appears on `irr_o` three clock edges after the input changes. The bit clears if the input falls before acknowledge. An input still held high after its acknowledge makes no new request.
- R3: With `level_mode_i` high, a high input is a request. A level still high after its acknowledge re-enters `irr_o` one edge after the acknowledge edge.
- R4: `mask_we_i` loads `mask_i` into the mask on the next edge, and `imr_o` bit n masks level n. A masked level neither raises `int_o` nor is granted, and lower levels are still granted past it.
- R5: `int_o` is high exactly when some unmasked pending level has a lower number than every in-service level (or nothing is in service).
- R6: On `ack_set_i` with an unmasked request pending, the granted level's in-service bit sets, its request bit clears, and `ack_level_o` shows its number from the next edge.
- R7: On `ack_set_i` with no unmasked request pending, `ack_level_o` becomes 7 and the in-service register is unchanged.
- R8: On `ack_end_i` with `auto_eoi_i` high, the in-service bit of the level granted by the preceding acknowledge clears. With `auto_eoi_i` low it stays set.
- R9: `eoi_i` clears the lowest-numbered set bit of the in-service register and no other.
- R10: After reset `irr_o`, `isr_o`, `imr_o` are zero and `int_o` is low. Bit n of each status port belongs to level n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 8 | Asynchronous request lines, bit n is level n |
| level_mode_i | input | 1 | 1: level-sensitive requests, 0: edge-sensitive |
| auto_eoi_i | input | 1 | 1: retire granted level at `ack_end_i` |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 8 | Mask write data, 1 masks the level |
| ack_set_i | input | 1 | Vector-setting acknowledge strobe, one cycle |
| ack_end_i | input | 1 | End of final acknowledge pulse, one cycle |
| eoi_i | input | 1 | Non-specific end-of-interrupt command, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| ack_level_o | output | 3 | Level number granted by the last acknowledge |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |

## Verification
The assertions take for granted that the acknowledge, acknowledge-end and end-of-interrupt strobes are single-cycle pulses that never coincide. They also assume that `level_mode_i` and `auto_eoi_i` change only while no acknowledge is in flight. The stimulus raises at most one strobe per cycle and holds each for exactly one clock. It changes mode bits only after the request lines have been idle long enough to drain the synchronizer.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NLVL  = 8;
  localparam int unsigned LVL_W = $clog2(NLVL);
  localparam int unsigned SYNC  = 2;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N = pic_pkg::NLVL,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int unsigned N    = pic_pkg::NLVL,
  parameter int unsigned SYNC = pic_pkg::SYNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ir_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] sync_q [SYNC];
  logic [N-1:0] prev_q, irr_q, irr_d, rise, line;

  assign line = sync_q[SYNC-1];
  assign rise = line & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= ir_i;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= line;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_comb begin
        if (level_mode_i) irr_d[g] = line[g] & ~clr_i[g];
        else              irr_d[g] = (irr_q[g] | rise[g]) & line[g] & ~clr_i[g];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irr_q <= '0;
    else         irr_q <= irr_d;
  end

  assign irr_o = irr_q;

  // R2: in edge mode a newly set request bit needs a detected rise
  a_r2_set_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!level_mode_i) |-> ((irr_q & ~$past(irr_q) & ~$past(rise)) == '0));
  // R2: a request never survives its line going low
  a_r2_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!level_mode_i) |-> ((irr_q & ~$past(line)) == '0));
  // R3: level mode follows the synchronized line when nothing is acknowledged
  a_r3_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_mode_i) && ($past(clr_i) == '0)) |-> (irr_q == $past(line)));
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int unsigned N = pic_pkg::NLVL,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ir_i,
  input  logic         level_mode_i,
  input  logic         auto_eoi_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  input  logic         ack_set_i,
  input  logic         ack_end_i,
  input  logic         eoi_i,
  output logic         int_o,
  output logic [W-1:0] ack_level_o,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o,
  output logic [N-1:0] imr_o
);
  localparam logic [W-1:0] SPURIOUS = W'(N - 1);

  logic [N-1:0] irr_q, imr_q, isr_q, isr_d, pend, grant_vec, aeoi_clr, eoi_clr;
  logic         pend_valid, isr_valid, ack_real_q;
  logic [W-1:0] pend_idx, isr_idx, ack_lvl_q;

  assign pend      = irr_q & ~imr_q;
  assign grant_vec = (ack_set_i && pend_valid) ? (N'(1) << pend_idx) : '0;

  pic_req_capture #(.N(N)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ir_i        (ir_i),
    .level_mode_i(level_mode_i),
    .clr_i       (grant_vec),
    .irr_o       (irr_q)
  );

  pic_prio_enc #(.N(N)) u_pend_enc (
    .req_i  (pend),
    .valid_o(pend_valid),
    .idx_o  (pend_idx)
  );

  pic_prio_enc #(.N(N)) u_isr_enc (
    .req_i  (isr_q),
    .valid_o(isr_valid),
    .idx_o  (isr_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        imr_q <= '0;
    else if (mask_we_i) imr_q <= mask_i;
  end

  assign aeoi_clr = (ack_end_i && auto_eoi_i && ack_real_q) ? (N'(1) << ack_lvl_q) : '0;
  assign eoi_clr  = (eoi_i && isr_valid) ? (N'(1) << isr_idx) : '0;
  assign isr_d    = (isr_q | grant_vec) & ~aeoi_clr & ~eoi_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q      <= '0;
      ack_lvl_q  <= '0;
      ack_real_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (ack_set_i) begin
        ack_lvl_q  <= pend_valid ? pend_idx : SPURIOUS;
        ack_real_q <= pend_valid;
      end else if (ack_end_i) begin
        ack_real_q <= 1'b0;
      end
    end
  end

  // nested priority: only a strictly more urgent level interrupts
  assign int_o       = pend_valid && (!isr_valid || (pend_idx < isr_idx));
  assign ack_level_o = ack_lvl_q;
  assign irr_o       = irr_q;
  assign isr_o       = isr_q;
  assign imr_o       = imr_q;

  a_r6_ack_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_set_i && pend_valid) |=> (isr_q[ack_level_o] && !irr_q[ack_level_o]));
  a_r7_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_set_i && !pend_valid && !eoi_i && !ack_end_i) |=>
      ((ack_level_o == SPURIOUS) && $stable(isr_q)));
  a_r9_eoi_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_set_i && !ack_end_i && (isr_q != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  a_r5_top_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_q[0] |-> !int_o);
  a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~imr_q) != '0));
endmodule

// File: tb/sim_pic_core.sv
module sim_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = '0, mask_d = '0;
  logic       lvl_mode = 1'b0, aeoi = 1'b0, mask_we = 1'b0;
  logic       ack_set = 1'b0, ack_end = 1'b0, eoi = 1'b0;
  logic       int_w;
  logic [2:0] lvl_w;
  logic [7:0] irr_w, isr_w, imr_w;

  always #2.5 clk = ~clk;

  pic_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .level_mode_i(lvl_mode),
    .auto_eoi_i(aeoi), .mask_we_i(mask_we), .mask_i(mask_d),
    .ack_set_i(ack_set), .ack_end_i(ack_end), .eoi_i(eoi),
    .int_o(int_w), .ack_level_o(lvl_w), .irr_o(irr_w), .isr_o(isr_w), .imr_o(imr_w)
  );

  typedef enum int {F_INT, F_LVL, F_IRR, F_ISR, F_IMR} field_e;
  typedef struct {
    string      tag;
    field_e     fld;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [7:0] act;
        it = q[0];
        case (it.fld)
          F_INT:   act = {7'd0, int_w};
          F_LVL:   act = {5'd0, lvl_w};
          F_IRR:   act = irr_w;
          F_ISR:   act = isr_w;
          default: act = imr_w;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s field %0d actual %h expected %h", it.tag, it.fld, act, it.exp);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic expect_v(string tag, field_e f, logic [7:0] e);
    item_t it;
    it.tag = tag; it.fld = f; it.exp = e;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack;  ack_set = 1; step(1); ack_set = 0; endtask
  task automatic pulse_end;  ack_end = 1; step(1); ack_end = 0; endtask
  task automatic pulse_eoi;  eoi = 1;     step(1); eoi = 0;     endtask
  task automatic write_mask(logic [7:0] m);
    mask_d = m; mask_we = 1; step(1); mask_we = 0;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_v("R10 reset irr", F_IRR, 8'h00);
    expect_v("R10 reset isr", F_ISR, 8'h00);
    expect_v("R10 reset imr", F_IMR, 8'h00);
    expect_v("R10 reset int", F_INT, 8'h00);
    rst_n = 1; step(2);

    // edge mode, levels 2 and 5
    ir = 8'h24; step(4);
    expect_v("R2 edge capture", F_IRR, 8'h24);
    expect_v("R5 int raised", F_INT, 8'h01);
    pulse_ack;
    expect_v("R1 R6 grant level", F_LVL, 8'd2);
    expect_v("R6 isr set", F_ISR, 8'h04);
    expect_v("R6 irr cleared", F_IRR, 8'h20);
    expect_v("R5 lower pending blocked", F_INT, 8'h00);
    pulse_end;
    expect_v("R8 no aeoi keeps isr", F_ISR, 8'h04);
    pulse_eoi;
    expect_v("R9 eoi clears", F_ISR, 8'h00);
    expect_v("R5 int after eoi", F_INT, 8'h01);

    // level 5 vanishes; level 2 still high after its ack
    ir = 8'h04; step(4);
    expect_v("R2 drop and no re-request", F_IRR, 8'h00);
    pulse_ack;
    expect_v("R7 spurious level", F_LVL, 8'd7);
    expect_v("R7 isr unchanged", F_ISR, 8'h00);

    // masking
    ir = 8'h00; step(4);
    write_mask(8'h01);
    expect_v("R4 mask loaded", F_IMR, 8'h01);
    ir = 8'h03; step(4);
    expect_v("R4 both pending", F_IRR, 8'h03);
    pulse_ack;
    expect_v("R4 grant past mask", F_LVL, 8'd1);
    expect_v("R4 isr level1", F_ISR, 8'h02);
    pulse_eoi;
    expect_v("R4 masked no int", F_INT, 8'h00);
    write_mask(8'h00);
    expect_v("R4 unmask int", F_INT, 8'h01);
    pulse_ack;
    expect_v("R1 grant level0", F_LVL, 8'd0);
    expect_v("R5 level0 in service", F_INT, 8'h00);

    // nesting: lower level arrives while 0 in service
    ir = 8'h0B; step(4);
    expect_v("R2 new edge level3", F_IRR, 8'h08);
    expect_v("R5 lower than service", F_INT, 8'h00);

    // auto EOI
    aeoi = 1;
    pulse_eoi;
    expect_v("R9 eoi level0", F_ISR, 8'h00);
    expect_v("R5 int for level3", F_INT, 8'h01);
    pulse_ack;
    expect_v("R6 grant level3", F_LVL, 8'd3);
    expect_v("R6 isr level3", F_ISR, 8'h08);
    pulse_end;
    expect_v("R8 aeoi clears", F_ISR, 8'h00);

    // level mode
    aeoi = 0; ir = 8'h00; step(4);
    lvl_mode = 1; ir = 8'h40; step(4);
    expect_v("R3 level capture", F_IRR, 8'h40);
    pulse_ack;
    expect_v("R6 level grant", F_LVL, 8'd6);
    expect_v("R6 irr cleared on ack", F_IRR, 8'h00);
    step(1);
    expect_v("R3 level re-request", F_IRR, 8'h40);
    ir = 8'h00; step(4);
    expect_v("R3 level released", F_IRR, 8'h00);
    pulse_eoi;
    expect_v("R9 final eoi", F_ISR, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule